// File: doc/BRIEF.md
# RAM, Port and Timer Bus Register Decoder

This block is the CPU-facing front end of a combined peripheral that holds a 128-byte scratch RAM, two 8-bit parallel ports and an interval timer. It takes a byte-wide bus (select, write enable, address, write data) and routes each access to one of these resources. Reads come back one cycle later on a registered read-data bus.

Each port has a held data register and a direction register. A data write changes only the bits that the direction register marks as outputs. The other bits keep their previous value. Each port pin is driven from its held bit where the direction bit is 1, and is released where the direction bit is 0.

The timer core lives outside this block. This block gives it a load strobe carrying the prescale choice, the interrupt-enable bit and the load value. It also gives a strobe that marks every read of the count, and it takes back the count and status bytes for reads. Reads and writes decode the register window differently.

Top module: `riot_bus_decode`

## Requirements
- R1: With address bit 9 at 0, a write stores the data byte in RAM at address bits 6:0, and a read of the same index returns that byte on `bus_rdata` after the next rising edge. Address bits 8:7 are not decoded, so indices alias.
- R2: With address bit 9 at 1, a read decodes address bits 2:0 as follows: 0 returns the port A pin inputs, 1 returns the port A direction register and 2 returns the port B pin inputs.
- R3: On the same read decode, codes 4 and 6 return `tmr_count` and codes 5 and 7 return `tmr_status`. `tmr_count_ack` is high in the cycle of a count read (codes 4 and 6) and at no other time.
- R4: A write with address bits 9, 4 and 2 all set raises `tmr_load` in the same cycle, with `tmr_prescale` equal to address bits 1:0, `tmr_irq_en` equal to address bit 3 and `tmr_load_val` equal to the write data. A write with bits 9 and 2 set but bit 4 clear changes nothing and raises no strobe.
- R5: A write with bit 9 set and bit 2 clear decodes address bits 1:0 as follows: 0 writes port A data, 1 writes the port A direction register, 2 writes port B data and 3 writes the port B direction register.
- R6: A port data write sets the held value to (data AND dir) OR (held AND NOT dir), so input-direction bits keep their value.
- R7: `pa_drive` and `pb_drive` show the held data, and `pa_oe` and `pb_oe` equal the direction registers (1 = output).
- R8: While reset is low, both direction registers, both held data registers and `bus_rdata` are zero.
- R9: The port B direction register takes effect on writes, but a read of code 3 returns zero.
- R10: With `bus_sel` low, no register changes and neither timer strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one cycle after the read |
| pa_pins_in | input | 8 | Sampled port A pin levels |
| pa_drive | output | 8 | Port A held data |
| pa_oe | output | 8 | Port A output enables |
| pb_pins_in | input | 8 | Sampled port B pin levels |
| pb_drive | output | 8 | Port B held data |
| pb_oe | output | 8 | Port B output enables |
| tmr_load | output | 1 | Timer load strobe |
| tmr_irq_en | output | 1 | Interrupt enable carried with the load |
| tmr_prescale | output | 2 | Prescale choice carried with the load |
| tmr_load_val | output | 8 | Load value |
| tmr_count_ack | output | 1 | Count-read strobe |
| tmr_count | input | 8 | Timer count for reads |
| tmr_status | input | 8 | Timer status for reads |

## Verification
Some properties are checked by assertions on every cycle:
- input-direction bits of the held data never change;
- the ignored timer gap and RAM writes leave the ports untouched;
- reads of the port B direction register return zero;
- no strobe is raised while the block is not selected;
- the reset values hold.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the value routing of every read code;
- RAM contents and aliasing;
- the merge arithmetic on data writes;
- the fields that travel with a timer load.

// File: rtl/riot_pkg.sv
package riot_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned RAM_SEL_BIT = 9;
  localparam int unsigned TMR_SEL_BIT = 2;
  localparam int unsigned TMR_WR_BIT  = 4;
  localparam int unsigned IRQ_EN_BIT  = 3;

  typedef enum logic [2:0] {
    SRC_RAM,
    SRC_PA_PINS,
    SRC_PA_DIR,
    SRC_PB_PINS,
    SRC_ZERO,
    SRC_COUNT,
    SRC_STATUS
  } rd_src_e;

  function automatic logic [DATA_W-1:0] merge_masked(
    input logic [DATA_W-1:0] held,
    input logic [DATA_W-1:0] fresh,
    input logic [DATA_W-1:0] dir
  );
    return (fresh & dir) | (held & ~dir);
  endfunction

  function automatic rd_src_e read_source(input logic [2:0] code);
    case (code)
      3'd0:    return SRC_PA_PINS;
      3'd1:    return SRC_PA_DIR;
      3'd2:    return SRC_PB_PINS;
      3'd3:    return SRC_ZERO;
      3'd4,
      3'd6:    return SRC_COUNT;
      default: return SRC_STATUS;
    endcase
  endfunction
endpackage

// File: rtl/riot_ram.sv
module riot_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= wdata;
    if (rd) q <= mem[idx];
  end
endmodule

// File: rtl/riot_port.sv
module riot_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic         dir_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] held,
  output logic [W-1:0] dir
);
  logic [W-1:0] merged;

  assign merged = riot_pkg::merge_masked(held, wdata, dir);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[b] <= 1'b0;
        dir[b]  <= 1'b0;
      end else begin
        if (data_wr) held[b] <= merged[b];
        if (dir_wr)  dir[b]  <= wdata[b];
      end
    end
  end
endmodule

// File: rtl/riot_decode.sv
module riot_decode
  import riot_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_wr,
  output logic              ram_rd,
  output logic              pa_data_wr,
  output logic              pa_dir_wr,
  output logic              pb_data_wr,
  output logic              pb_dir_wr,
  output logic              tmr_wr,
  output logic              cnt_rd,
  output logic              io_rd,
  output rd_src_e           src
);
  logic in_io, is_wr, is_rd, reg_wr;

  assign in_io  = addr[RAM_SEL_BIT];
  assign is_wr  = sel & we;
  assign is_rd  = sel & ~we;
  assign reg_wr = is_wr & in_io & ~addr[TMR_SEL_BIT];

  assign ram_wr     = is_wr & ~in_io;
  assign ram_rd     = is_rd & ~in_io;
  assign io_rd      = is_rd & in_io;
  assign pa_data_wr = reg_wr & (addr[1:0] == 2'd0);
  assign pa_dir_wr  = reg_wr & (addr[1:0] == 2'd1);
  assign pb_data_wr = reg_wr & (addr[1:0] == 2'd2);
  assign pb_dir_wr  = reg_wr & (addr[1:0] == 2'd3);
  assign tmr_wr     = is_wr & in_io & addr[TMR_SEL_BIT] & addr[TMR_WR_BIT];
  assign src        = in_io ? read_source(addr[2:0]) : SRC_RAM;
  assign cnt_rd     = io_rd & (src == SRC_COUNT);
endmodule

// File: rtl/riot_bus_decode.sv
module riot_bus_decode
  import riot_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned RAM_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pa_pins_in,
  output logic [7:0]        pa_drive,
  output logic [7:0]        pa_oe,
  input  logic [7:0]        pb_pins_in,
  output logic [7:0]        pb_drive,
  output logic [7:0]        pb_oe,
  output logic              tmr_load,
  output logic              tmr_irq_en,
  output logic [1:0]        tmr_prescale,
  output logic [7:0]        tmr_load_val,
  output logic              tmr_count_ack,
  input  logic [7:0]        tmr_count,
  input  logic [7:0]        tmr_status
);
  logic ram_wr, ram_rd, pa_data_wr, pa_dir_wr, pb_data_wr, pb_dir_wr;
  logic tmr_wr, cnt_rd, io_rd;
  rd_src_e src, src_q;
  logic [7:0] ram_q, io_val, io_q;
  logic [7:0] pa_dir, pb_dir;

  riot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .ram_wr(ram_wr), .ram_rd(ram_rd),
    .pa_data_wr(pa_data_wr), .pa_dir_wr(pa_dir_wr),
    .pb_data_wr(pb_data_wr), .pb_dir_wr(pb_dir_wr),
    .tmr_wr(tmr_wr), .cnt_rd(cnt_rd), .io_rd(io_rd), .src(src)
  );

  riot_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .wr(ram_wr), .rd(ram_rd),
    .idx(bus_addr[RAM_AW-1:0]), .wdata(bus_wdata), .q(ram_q)
  );

  riot_port #(.W(DATA_W)) u_pa (
    .clk(clk), .rst_n(rst_n), .data_wr(pa_data_wr), .dir_wr(pa_dir_wr),
    .wdata(bus_wdata), .held(pa_drive), .dir(pa_dir)
  );

  riot_port #(.W(DATA_W)) u_pb (
    .clk(clk), .rst_n(rst_n), .data_wr(pb_data_wr), .dir_wr(pb_dir_wr),
    .wdata(bus_wdata), .held(pb_drive), .dir(pb_dir)
  );

  always_comb begin
    case (src)
      SRC_PA_PINS: io_val = pa_pins_in;
      SRC_PA_DIR:  io_val = pa_dir;
      SRC_PB_PINS: io_val = pb_pins_in;
      SRC_COUNT:   io_val = tmr_count;
      SRC_STATUS:  io_val = tmr_status;
      default:     io_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_ZERO;
      io_q  <= '0;
    end else if (ram_rd || io_rd) begin
      src_q <= src;
      io_q  <= io_val;
    end
  end

  assign bus_rdata     = (src_q == SRC_RAM) ? ram_q : io_q;
  assign pa_oe         = pa_dir;
  assign pb_oe         = pb_dir;
  assign tmr_load      = tmr_wr;
  assign tmr_irq_en    = bus_addr[IRQ_EN_BIT];
  assign tmr_prescale  = bus_addr[1:0];
  assign tmr_load_val  = bus_wdata;
  assign tmr_count_ack = cnt_rd;
endmodule

// File: rtl/riot_bus_chk.sv
module riot_bus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_we,
  input logic [9:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic [7:0] pa_drive,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_drive,
  input logic [7:0] pb_oe,
  input logic       tmr_load,
  input logic       tmr_count_ack
);
  a_r6_input_bits_kept_a: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pa_drive ^ $past(pa_drive)) & ~$past(pa_oe)) == 8'h00));

  a_r6_input_bits_kept_b: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pb_drive ^ $past(pb_drive)) & ~$past(pb_oe)) == 8'h00));

  a_r4_gap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[9] && bus_addr[2] && !bus_addr[4])
    |-> !tmr_load ##1 ($stable(pa_drive) && $stable(pa_oe) && $stable(pb_drive) && $stable(pb_oe)));

  a_r1_ram_write_no_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !bus_addr[9])
    |=> ($stable(pa_drive) && $stable(pa_oe) && $stable(pb_drive) && $stable(pb_oe)));

  a_r9_dirb_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[9] && bus_addr[2:0] == 3'd3) |=> (bus_rdata == 8'h00));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (!tmr_load && !tmr_count_ack));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> ($stable(pa_drive) && $stable(pa_oe) && $stable(pb_drive) && $stable(pb_oe)));

  a_r8_reset_values: assert property (@(posedge clk)
    !rst_n |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pa_drive == 8'h00 &&
                pb_drive == 8'h00 && bus_rdata == 8'h00));
endmodule

bind riot_bus_decode riot_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pa_drive(pa_drive), .pa_oe(pa_oe), .pb_drive(pb_drive), .pb_oe(pb_oe),
  .tmr_load(tmr_load), .tmr_count_ack(tmr_count_ack)
);

// File: tb/sim_riot_bus_decode.sv
`timescale 1ns/1ps
module sim_riot_bus_decode;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_pins_in = 8'h00, pb_pins_in = 8'h00;
  logic [7:0] pa_drive, pa_oe, pb_drive, pb_oe;
  logic       tmr_load, tmr_irq_en, tmr_count_ack;
  logic [1:0] tmr_prescale;
  logic [7:0] tmr_load_val;
  logic [7:0] tmr_count = 8'h00, tmr_status = 8'h00;

  always #5 clk = ~clk;

  riot_bus_decode u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_pins_in(pa_pins_in), .pa_drive(pa_drive), .pa_oe(pa_oe),
    .pb_pins_in(pb_pins_in), .pb_drive(pb_drive), .pb_oe(pb_oe),
    .tmr_load(tmr_load), .tmr_irq_en(tmr_irq_en), .tmr_prescale(tmr_prescale),
    .tmr_load_val(tmr_load_val), .tmr_count_ack(tmr_count_ack),
    .tmr_count(tmr_count), .tmr_status(tmr_status)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int  m_ram [128];
  bit  m_ram_ok [128];
  int  m_pa, m_pb, m_da, m_db;
  int  m_rd;
  bit  m_rd_ok;
  string m_rd_tag;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_da = 0; m_db = 0;
      m_rd = 0; m_rd_ok = 1; m_rd_tag = "R8 reset rdata";
    end else if (bus_sel && bus_we) begin
      if (!bus_addr[9]) begin
        m_ram[bus_addr % 128] = bus_wdata;
        m_ram_ok[bus_addr % 128] = 1;
      end else if (!bus_addr[2]) begin
        case (bus_addr % 4)
          0: m_pa = (m_pa & ~m_da & 255) | (bus_wdata & m_da);
          1: m_da = bus_wdata;
          2: m_pb = (m_pb & ~m_db & 255) | (bus_wdata & m_db);
          default: m_db = bus_wdata;
        endcase
      end
    end else if (bus_sel) begin
      if (!bus_addr[9]) begin
        m_rd_ok = m_ram_ok[bus_addr % 128];
        m_rd = m_ram[bus_addr % 128];
        m_rd_tag = "R1 ram read";
      end else begin
        m_rd_ok = 1;
        case (bus_addr % 8)
          0: begin m_rd = pa_pins_in; m_rd_tag = "R2 port A pins"; end
          1: begin m_rd = m_da;       m_rd_tag = "R2 dir A read"; end
          2: begin m_rd = pb_pins_in; m_rd_tag = "R2 port B pins"; end
          3: begin m_rd = 0;          m_rd_tag = "R9 dir B reads zero"; end
          4, 6: begin m_rd = tmr_count;  m_rd_tag = "R3 count read"; end
          default: begin m_rd = tmr_status; m_rd_tag = "R3 status read"; end
        endcase
      end
    end
  end

  // compare registered outputs every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 R5 R6 port A drive", pa_drive, m_pa);
      check("R7 R5 port A oe", pa_oe, m_da);
      check("R7 R5 R6 port B drive", pb_drive, m_pb);
      check("R7 R5 port B oe", pb_oe, m_db);
      if (m_rd_ok) check(m_rd_tag, bus_rdata, m_rd);
    end
  end

  task automatic strobe_check(input int ld, input int ack);
    #2;
    check("R4 R10 tmr_load", tmr_load, ld);
    check("R3 R10 tmr_count_ack", tmr_count_ack, ack);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a[9:0]; bus_wdata = d[7:0];
    if (a[9] && a[2] && a[4]) begin
      strobe_check(1, 0);
      check("R4 prescale", tmr_prescale, a & 3);
      check("R4 irq enable", tmr_irq_en, (a >> 3) & 1);
      check("R4 load value", tmr_load_val, d & 255);
    end else strobe_check(0, 0);
  endtask

  task automatic rd(input int a);
    @(negedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a[9:0];
    strobe_check(0, (a[9] && (a % 8 == 4 || a % 8 == 6)) ? 1 : 0);
  endtask

  task automatic idle(input int a);
    @(negedge clk); #1;
    bus_sel = 0; bus_we = 1; bus_addr = a[9:0]; bus_wdata = 8'hFF;
    strobe_check(0, 0);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset rdata", bus_rdata, 0);
    check("R8 reset dir A", pa_oe, 0);
    check("R8 reset dir B", pb_oe, 0);
    check("R8 reset drive", {pa_drive, pb_drive}, 0);
    @(negedge clk); rst_n = 1;

    // ports: direction and merge (R5, R6, R7)
    wr(10'h201, 8'hF0);
    wr(10'h200, 8'hAB);
    rd(10'h201);
    wr(10'h203, 8'h0F);
    rd(10'h203);
    wr(10'h202, 8'h5C);
    wr(10'h201, 8'hFF);
    wr(10'h200, 8'h12);
    wr(10'h201, 8'h00);
    wr(10'h200, 8'hFF);
    wr(10'h213, 8'hF0);   // bit4 set, bit2 clear: still port B dir (R5)
    wr(10'h212, 8'hA5);
    // pins (R2)
    pa_pins_in = 8'h3C; pb_pins_in = 8'hC3;
    rd(10'h200); rd(10'h202); rd(10'h2F8); rd(10'h2FA);
    // RAM (R1) with aliasing of bits 8:7
    wr(10'h000, 8'h11); wr(10'h07F, 8'h7F); wr(10'h105, 8'h55);
    rd(10'h000); rd(10'h07F); rd(10'h185); rd(10'h005);
    wr(10'h1FF, 8'h99); rd(10'h07F);
    // timer window (R3, R4)
    tmr_count = 8'h42; tmr_status = 8'h80;
    wr(10'h214, 8'h10); wr(10'h21F, 8'hFF); wr(10'h21A, 8'h07);
    wr(10'h204, 8'hEE); wr(10'h20C, 8'h01); wr(10'h207, 8'h02);
    rd(10'h204); rd(10'h205); rd(10'h206); rd(10'h207);
    tmr_count = 8'h00; tmr_status = 8'h00;
    rd(10'h21C); rd(10'h21D);
    // deselected traffic (R10)
    idle(10'h200); idle(10'h214); idle(10'h204); idle(10'h001);
    rd(10'h001);
    // pseudo-random mix
    lfsr = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      pa_pins_in = lfsr[7:0]; pb_pins_in = lfsr[15:8];
      tmr_count = lfsr[11:4]; tmr_status = {lfsr[3], 7'd0};
      case (lfsr % 4)
        0: wr({lfsr[9], 4'b0, lfsr[4:0]}, lfsr[15:8]);
        1: rd({lfsr[9], 2'b0, lfsr[6:0]});
        2: wr({lfsr[9] | lfsr[2], 3'b0, lfsr[5:0]}, lfsr[14:7]);
        default: idle(lfsr[9:0]);
      endcase
    end
    idle(0); idle(0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule